// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block is the clock-master timing source for an audio serial port. It divides the reference clock into a serial bit clock. It counts bit clocks to mark out frames, and it drives a frame-sync signal whose width and active level follow the selected audio format (I2S, left-justified, DSP-A or DSP-B). The shift logic also receives a one-cycle frame-start strobe at the first reference cycle of every frame.

Settings are captured into shadow registers by a load strobe, and only while the generator is disabled. When the captured setting selects slave operation, the generator stops. The external bit clock and frame sync then pass straight through to the outputs. Software computes the divider and frame fields. A bit period is (divider field + 1) reference cycles, and a frame is (period field + 1) bit periods.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the captured setting is slave mode with all fields zero: bclk_o equals ext_bclk_i, fs_o equals ext_fs_i, and frame_start_o is 0.
- R2: A high cfg_we_i loads every configuration field on a clock edge where en_i is low. While en_i is high, cfg_we_i has no effect, and the running frame timing keeps the earlier setting, including after a later re-enable.
- R3: In master mode a bit period lasts div_i+1 reference cycles. Before inversion, the bit clock is low for the first floor((div_i+1)/2) cycles of each period and high for the rest. A field of 0 divides by 1, and the un-inverted bit clock then stays high.
- R4: Frames last (fper_i+1) bit periods, which is (fper_i+1)·(div_i+1) reference cycles. frame_start_o is high for exactly one reference cycle per frame, in the first cycle of the frame.
- R5: While en_i is low all counters are cleared. The first frame_start_o pulse appears in the (fper_i+1)·(div_i+1)-th cycle, counting the first clock edge that samples en_i high as cycle 1. Dropping en_i in mid-frame and raising it again restarts this full wait.
- R6: For fmt_i = 0 (I2S) and fmt_i = 1 (left-justified), frame sync is active for fwid_i+1 bit periods, starting in the frame-start cycle. The width is capped at the frame length.
- R7: For fmt_i = 2 (DSP-A) and fmt_i = 3 (DSP-B), frame sync is active for exactly one bit period from the frame-start cycle, whatever the value of fwid_i.
- R8: The active level of fs_o is low for I2S and high for the other three formats. A set fs_inv_i flips this level.
- R9: A set bclk_inv_i flips bclk_o relative to the R3 waveform.
- R10: In master mode with en_i low, bclk_o sits at the level of bclk_inv_i and fs_o sits at its inactive level.
- R11: In slave mode, bclk_o and fs_o follow ext_bclk_i and ext_fs_i, and frame_start_o stays 0 whatever en_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the counters and opens the configuration |
| cfg_we_i | input | 1 | Configuration load strobe, accepted only while en_i is low |
| master_i | input | 1 | 1 = generate clocks, 0 = forward external clocks |
| div_i | input | 8 | Bit-clock divider field (period − 1) |
| fper_i | input | 12 | Frame-period field (bit periods − 1) |
| fwid_i | input | 8 | Frame-sync width field (bit periods − 1), used in I2S and left-justified |
| fmt_i | input | 2 | Format: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| bclk_inv_i | input | 1 | Invert the bit clock |
| fs_inv_i | input | 1 | Invert the frame-sync polarity |
| ext_bclk_i | input | 1 | External bit clock used in slave mode |
| ext_fs_i | input | 1 | External frame sync used in slave mode |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| frame_start_o | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
A bit counter that has slipped shows up at the very next frame boundary. The spacing of frame_start_o then differs from (fper+1)·(div+1), or the first pulse after enable arrives early or late. A phase counter that is off changes the number of high cycles of bclk_o within one bit period. A frame-sync window of the wrong size, or a wrong started flag, changes the count of active fs_o cycles in the first measured frame, or makes fs_o active before the first strobe. A configuration write that leaks in while the generator is enabled changes the frame length within one frame.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_DSP_A = 2'd2,
    FMT_DSP_B = 2'd3
  } fmt_e;

  function automatic logic fmt_is_dsp(fmt_e f);
    return f == FMT_DSP_A || f == FMT_DSP_B;
  endfunction

  // I2S idles high (active low); the others idle low unless inverted
  function automatic logic fs_active_level(fmt_e f, logic inv);
    return inv ^ (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PER_W-1:0] fper_i,
  input  logic [WID_W-1:0] fwid_i,
  input  logic [1:0]       fmt_i,
  input  logic             bclk_inv_i,
  input  logic             fs_inv_i,
  output logic             master_o,
  output logic [DIV_W-1:0] div_o,
  output logic [PER_W-1:0] fper_o,
  output logic [WID_W-1:0] fwid_o,
  output fmt_e             fmt_o,
  output logic             bclk_inv_o,
  output logic             fs_inv_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_o   <= 1'b0;
      div_o      <= '0;
      fper_o     <= '0;
      fwid_o     <= '0;
      fmt_o      <= FMT_I2S;
      bclk_inv_o <= 1'b0;
      fs_inv_o   <= 1'b0;
    end else if (we_i && !en_i) begin
      master_o   <= master_i;
      div_o      <= div_i;
      fper_o     <= fper_i;
      fwid_o     <= fwid_i;
      fmt_o      <= fmt_e'(fmt_i);
      bclk_inv_o <= bclk_inv_i;
      fs_inv_o   <= fs_inv_i;
    end
  end

endmodule

// File: rtl/audio_clkgen_bitdiv.sv
module audio_clkgen_bitdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             bclk_o
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] ph_q, ph_nxt;
  logic [CNT_W-1:0] half;

  // low phase length: floor((div+1)/2)
  assign half   = ({1'b0, div_i} + CNT_W'(1)) >> 1;
  assign tick_o = run_i && (ph_q == div_i);
  assign ph_nxt = tick_o ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      bclk_o <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      bclk_o <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      bclk_o <= ({1'b0, ph_nxt} >= half);
    end
  end

endmodule

// File: rtl/audio_clkgen_frame.sv
module audio_clkgen_frame #(
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             dsp_i,
  input  logic [PER_W-1:0] fper_i,
  input  logic [WID_W-1:0] fwid_i,
  output logic             fs_act_o,
  output logic             fstart_o
);

  localparam int unsigned CMP_W = ((PER_W > WID_W) ? PER_W : WID_W) + 1;

  logic [PER_W-1:0] bcnt_q, bcnt_nxt;
  logic             started_q, started_nxt;
  logic             wrap;
  logic [CMP_W-1:0] width;

  assign wrap        = tick_i && (bcnt_q == fper_i);
  assign bcnt_nxt    = wrap ? '0 : bcnt_q + 1'b1;
  assign started_nxt = started_q | wrap;
  assign width       = dsp_i ? CMP_W'(1) : CMP_W'(fwid_i) + CMP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q    <= '0;
      started_q <= 1'b0;
      fs_act_o  <= 1'b0;
      fstart_o  <= 1'b0;
    end else if (!run_i) begin
      bcnt_q    <= '0;
      started_q <= 1'b0;
      fs_act_o  <= 1'b0;
      fstart_o  <= 1'b0;
    end else begin
      fstart_o <= wrap;
      if (tick_i) begin
        bcnt_q    <= bcnt_nxt;
        started_q <= started_nxt;
        fs_act_o  <= started_nxt && (CMP_W'(bcnt_nxt) < width);
      end
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cfg_we_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PER_W-1:0] fper_i,
  input  logic [WID_W-1:0] fwid_i,
  input  logic [1:0]       fmt_i,
  input  logic             bclk_inv_i,
  input  logic             fs_inv_i,
  input  logic             ext_bclk_i,
  input  logic             ext_fs_i,
  output logic             bclk_o,
  output logic             fs_o,
  output logic             frame_start_o
);

  logic             cfg_master, cfg_bclk_inv, cfg_fs_inv;
  logic [DIV_W-1:0] cfg_div;
  logic [PER_W-1:0] cfg_fper;
  logic [WID_W-1:0] cfg_fwid;
  fmt_e             cfg_fmt;
  logic             run, tick, bclk_raw, fs_act, fstart, act_lvl;

  audio_clkgen_cfg #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .we_i       (cfg_we_i),
    .master_i   (master_i),
    .div_i      (div_i),
    .fper_i     (fper_i),
    .fwid_i     (fwid_i),
    .fmt_i      (fmt_i),
    .bclk_inv_i (bclk_inv_i),
    .fs_inv_i   (fs_inv_i),
    .master_o   (cfg_master),
    .div_o      (cfg_div),
    .fper_o     (cfg_fper),
    .fwid_o     (cfg_fwid),
    .fmt_o      (cfg_fmt),
    .bclk_inv_o (cfg_bclk_inv),
    .fs_inv_o   (cfg_fs_inv)
  );

  assign run = en_i && cfg_master;

  audio_clkgen_bitdiv #(.DIV_W(DIV_W)) bitdiv_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (cfg_div),
    .tick_o (tick),
    .bclk_o (bclk_raw)
  );

  audio_clkgen_frame #(.PER_W(PER_W), .WID_W(WID_W)) frame_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick),
    .dsp_i    (fmt_is_dsp(cfg_fmt)),
    .fper_i   (cfg_fper),
    .fwid_i   (cfg_fwid),
    .fs_act_o (fs_act),
    .fstart_o (fstart)
  );

  assign act_lvl       = fs_active_level(cfg_fmt, cfg_fs_inv);
  assign bclk_o        = cfg_master ? (bclk_raw ^ cfg_bclk_inv) : ext_bclk_i;
  assign fs_o          = cfg_master ? (fs_act ? act_lvl : ~act_lvl) : ext_fs_i;
  assign frame_start_o = fstart;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             fs_o,
  input logic             frame_start_o,
  input logic             master_i,
  input logic [1:0]       fmt_i,
  input logic             fs_inv_i,
  input logic [DIV_W-1:0] div_i,
  input logic [PER_W-1:0] fper_i
);

  logic exp_lvl, fs_on;
  assign exp_lvl = fs_inv_i ^ (fmt_i != 2'd0);
  assign fs_on   = master_i && en_i && (fs_o == exp_lvl);

  // R2
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ($stable(div_i) && $stable(fper_i) && $stable(fmt_i)));

  // R5
  no_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !frame_start_o);

  // R4
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && (div_i != '0 || fper_i != '0)) |=> !frame_start_o);

  // R8
  fs_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && master_i) |-> (fs_o == exp_lvl));

  // R6
  fs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_on) |-> frame_start_o);

  // R11
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !frame_start_o);

endmodule

bind audio_clkgen audio_clkgen_chk #(.DIV_W(DIV_W), .PER_W(PER_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .fs_o          (fs_o),
  .frame_start_o (frame_start_o),
  .master_i      (cfg_master),
  .fmt_i         (cfg_fmt),
  .fs_inv_i      (cfg_fs_inv),
  .div_i         (cfg_div),
  .fper_i        (cfg_fper)
);

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, cfg_we = 1'b0, master = 1'b0;
  logic [7:0]  div = '0;
  logic [11:0] fper = '0;
  logic [7:0]  fwid = '0;
  logic [1:0]  fmt = '0;
  logic        bclk_inv = 1'b0, fs_inv = 1'b0;
  logic        ext_bclk = 1'b0, ext_fs = 1'b0;
  logic        bclk, fs, fstart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_clkgen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .en_i          (en),
    .cfg_we_i      (cfg_we),
    .master_i      (master),
    .div_i         (div),
    .fper_i        (fper),
    .fwid_i        (fwid),
    .fmt_i         (fmt),
    .bclk_inv_i    (bclk_inv),
    .fs_inv_i      (fs_inv),
    .ext_bclk_i    (ext_bclk),
    .ext_fs_i      (ext_fs),
    .bclk_o        (bclk),
    .fs_o          (fs),
    .frame_start_o (fstart)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic configure(int dv, int fp, int fw, int fm, int bi, int fi, int ms);
    @(negedge clk);
    en = 1'b0;
    div = 8'(dv); fper = 12'(fp); fwid = 8'(fw); fmt = 2'(fm);
    bclk_inv = bi[0]; fs_inv = fi[0]; master = ms[0];
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // raise en at a negedge, count edges until frame_start_o is seen
  task automatic first_start(int limit, output int n);
    en = 1'b1;
    n = 0;
    for (int k = 0; k < limit; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (fstart) break;
    end
  endtask

  task automatic run_master(int dv, int fp, int fw, int fm, int bi, int fi);
    int p, w, act, n, fsa, bh, extra, raw;
    p   = (fp + 1) * (dv + 1);
    w   = (fm < 2) ? fw + 1 : 1;
    if (w > fp + 1) w = fp + 1;
    act = fi ^ ((fm != 0) ? 1 : 0);
    raw = (fp + 1) * ((dv + 1) - ((dv + 1) >> 1));
    configure(dv, fp, fw, fm, bi, fi, 1);
    chk(bclk == bi[0], "R10", "idle bclk", int'(bclk), bi);
    chk(fs == !act[0], "R10", "idle fs", int'(fs), 1 - act);
    first_start(p + 8, n);
    chk(n == p, "R5", "cycles to first frame start", n, p);
    fsa = 0; bh = 0; extra = 0;
    for (int i = 0; i < p; i++) begin
      if (i == 0) chk(fs == act[0], "R8", "fs level at frame start", int'(fs), act);
      if (i > 0 && fstart) extra++;
      if (fs == act[0]) fsa++;
      if (bclk) bh++;
      @(negedge clk);
    end
    chk(fstart == 1'b1, "R4", "frame start after one period", int'(fstart), 1);
    chk(extra == 0, "R4", "extra strobes in frame", extra, 0);
    chk(fsa == w * (dv + 1), (fm < 2) ? "R6" : "R7", "fs active cycles", fsa, w * (dv + 1));
    chk(bh == (bi ? p - raw : raw), bi ? "R9" : "R3", "bclk high cycles", bh, bi ? p - raw : raw);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    ext_bclk = 1'b1; ext_fs = 1'b0;
    @(negedge clk);
    chk(bclk == 1'b1 && fs == 1'b0, "R1", "reset forwards ext", int'({bclk, fs}), 2);
    chk(fstart == 1'b0, "R1", "reset frame start", int'(fstart), 0);
  endtask

  task automatic test_cfg_locked();
    int n;
    configure(1, 7, 3, 0, 0, 0, 1);
    en = 1'b1;
    repeat (5) @(negedge clk);
    div = 8'd3; fper = 12'd15; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    en = 1'b0;
    @(negedge clk);
    first_start(40, n);
    chk(n == 16, "R2", "write while enabled ignored", n, 16);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_midframe_restart();
    int n;
    configure(1, 9, 4, 1, 0, 0, 1);
    en = 1'b1;
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(fs == 1'b0 && bclk == 1'b0, "R10", "disabled mid-frame idles", int'({bclk, fs}), 0);
    first_start(40, n);
    chk(n == 20, "R5", "restart after mid-frame disable", n, 20);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_slave();
    int bad;
    configure(1, 3, 1, 0, 1, 1, 0);
    en = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      ext_bclk = i[0]; ext_fs = i[2];
      #1;
      if (bclk != ext_bclk || fs != ext_fs) bad++;
      @(negedge clk);
      if (fstart) bad++;
    end
    chk(bad == 0, "R11", "slave forwarding and no strobe", bad, 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_master(1, 7, 3, 0, 0, 0);   // I2S
    run_master(3, 15, 7, 1, 0, 0);  // left-justified
    run_master(2, 9, 9, 2, 0, 1);   // DSP-A, fwid ignored, fs inverted
    run_master(1, 5, 0, 3, 1, 0);   // DSP-B, bclk inverted
    run_master(0, 3, 1, 0, 0, 1);   // divide by 1
    run_master(1, 3, 7, 0, 0, 0);   // width capped at frame
    test_cfg_locked();
    test_midframe_restart();
    test_slave();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule